// File: doc/BRIEF.md
# Supervised Store Buffer with Deferred Metadata Exceptions

This block sits between an in-order core and memory and holds up to four outstanding stores. Each entry records the store's virtual address, its data, whether it was issued as a supervised store, and the outcome of the metadata check made when the store was accepted. Entries leave for memory strictly oldest first. A plain load can take its value from the youngest buffered store to the same address. A supervised load never takes a value from the buffer. Instead it is told to wait while any buffered store touches its block.

A supervised store whose metadata check failed is not written when it reaches the head. The buffer reports one late exception pulse and becomes busy. It then streams every buffered entry, the failing one first, out of a valid/ready dump port. Entries go out one at a time and a fixed gap of idle cycles comes before each one. A deferred handler can use the dump to inspect or replay the stores. The core is held off for the whole dump. Once the last entry is taken, the buffer is empty and accepts stores again.

Top module: `sup_store_buffer`

## Requirements
- R1: After synchronous reset the buffer is empty: `st_stall`, `wr_valid`, `exc_pulse`, `busy`, `dump_valid`, `ld_hit` and `ld_wait` are all low.
- R2: Stores are presented on the write port in the order they were accepted. The head entry stays on `wr_valid`/`wr_addr`/`wr_data`, unchanged, until `wr_ready` is high.
- R3: With four entries held, `st_stall` is high and a store offered while stalled is ignored. It is never written or dumped.
- R4: A plain load (`ld_super`=0) whose full address equals that of one or more buffered entries gets `ld_hit`=1 and the data of the youngest such entry. Otherwise `ld_hit`=0.
- R5: A supervised load (`ld_super`=1) never gets `ld_hit`=1, even on an exact address match.
- R6: For a supervised load, `ld_wait` is high exactly while some buffered entry has equal address bits above bit `BLK_LSB`-1 (same block). It is always low for plain loads.
- R7: A supervised entry with `st_fault`=1 is never written to memory. When it is at the head with the buffer idle, `exc_pulse` is high for exactly that one cycle and the buffer becomes busy on the next cycle.
- R8: While busy, entries leave on the dump port oldest first, carrying address, data and supervised flag. Each entry is preceded by `DUMP_GAP` cycles with `dump_valid` low and is then held until `dump_ready`.
- R9: While busy, `st_stall` is high, offered stores are ignored and `wr_valid` is low. After the last dumped entry is accepted, `busy` falls and the buffer is empty.
- R10: `st_fault` is ignored for plain stores (`st_super`=0): such a store retires to memory normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Core offers a store |
| st_addr | input | 32 | Store virtual address |
| st_data | input | 32 | Store data |
| st_super | input | 1 | Store is supervised |
| st_fault | input | 1 | Metadata check of a supervised store hit an exception state |
| st_stall | output | 1 | Store not accepted this cycle (full or busy) |
| ld_valid | input | 1 | Core issues a load lookup |
| ld_addr | input | 32 | Load address |
| ld_super | input | 1 | Load is supervised |
| ld_hit | output | 1 | Plain load forwarded from the buffer |
| ld_data | output | 32 | Forwarded data |
| ld_wait | output | 1 | Supervised load must wait for a same-block store |
| wr_valid | output | 1 | Head store offered to memory |
| wr_addr | output | 32 | Address of head store |
| wr_data | output | 32 | Data of head store |
| wr_ready | input | 1 | Memory accepts the head store |
| exc_pulse | output | 1 | Late metadata exception raised |
| busy | output | 1 | Dump in progress |
| dump_valid | output | 1 | Dump entry available |
| dump_addr | output | 32 | Dumped entry virtual address |
| dump_data | output | 32 | Dumped entry data |
| dump_super | output | 1 | Dumped entry supervised flag |
| dump_ready | input | 1 | Handler side takes the dump entry |

## Verification
Directed stimulus fills the buffer while memory is stalled. This separates ordering from back-pressure and shows that a fifth store is dropped. Plain and supervised loads probe a repeated address, which tells youngest-entry forwarding apart from oldest-entry forwarding. They also probe a same-block, different-word address, which tells block matching for the wait signal apart from full-address matching for forwarding. A faulting supervised store at the head, followed by mixed entries and a stuttering `dump_ready`, exercises gap timing, dump order and the ignored stores during the dump. A long pseudo-random phase with small address sets, random memory readiness and occasional faults then compares every output each cycle against a queue-based model.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    localparam int SB_AW = 32;
    localparam int SB_DW = 32;

    typedef struct packed {
        logic [SB_AW-1:0] addr;
        logic [SB_DW-1:0] data;
        logic             sup;
        logic             fault;
    } sb_entry_t;

    typedef enum logic [1:0] {
        DS_RUN  = 2'd0,
        DS_GAP  = 2'd1,
        DS_SEND = 2'd2
    } dump_state_t;

    function automatic logic same_block(input logic [SB_AW-1:0] a,
                                        input logic [SB_AW-1:0] b,
                                        input int unsigned lsb);
        return (a >> lsb) == (b >> lsb);
    endfunction

endpackage

// File: rtl/sbuf_fifo.sv
module sbuf_fifo
    import sbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                push,
    input  sb_entry_t           push_ent,
    input  logic                pop,
    output sb_entry_t           head_ent,
    output logic [PW-1:0]       head_ptr,
    output logic [CW-1:0]       count,
    output logic [SB_AW-1:0]    addr_q [DEPTH],
    output logic [SB_DW-1:0]    data_q [DEPTH]
);

    sb_entry_t     slots [DEPTH];
    logic [PW-1:0] tail_ptr;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            head_ptr <= '0;
            tail_ptr <= '0;
            count    <= '0;
        end else begin
            if (push) begin
                slots[tail_ptr] <= push_ent;
                tail_ptr        <= wrap_inc(tail_ptr);
            end
            if (pop) head_ptr <= wrap_inc(head_ptr);
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assign head_ent = slots[head_ptr];

    for (genvar g = 0; g < DEPTH; g++) begin : g_view
        assign addr_q[g] = slots[g].addr;
        assign data_q[g] = slots[g].data;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH)); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop |-> count != '0); // R2

endmodule

// File: rtl/sbuf_lookup.sv
module sbuf_lookup
    import sbuf_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int BLK_LSB = 6,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [SB_AW-1:0] addr_q [DEPTH],
    input  logic [SB_DW-1:0] data_q [DEPTH],
    input  logic [PW-1:0]    head_ptr,
    input  logic [CW-1:0]    count,
    input  logic             ld_valid,
    input  logic [SB_AW-1:0] ld_addr,
    input  logic             ld_super,
    output logic             ld_hit,
    output logic [SB_DW-1:0] ld_data,
    output logic             ld_wait
);

    logic             any_exact;
    logic             any_block;
    logic [SB_DW-1:0] young_data;

    // Walk oldest to youngest so the last exact match wins.
    always_comb begin
        any_exact  = 1'b0;
        any_block  = 1'b0;
        young_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            int            pos;
            logic [PW-1:0] idx;
            pos = int'(head_ptr) + i;
            if (pos >= DEPTH) pos = pos - DEPTH;
            idx = PW'(pos);
            if (i < int'(count)) begin
                if (addr_q[idx] == ld_addr) begin
                    any_exact  = 1'b1;
                    young_data = data_q[idx];
                end
                if (same_block(addr_q[idx], ld_addr, BLK_LSB)) any_block = 1'b1;
            end
        end
    end

    assign ld_hit  = ld_valid && !ld_super && any_exact;
    assign ld_data = ld_hit ? young_data : '0;
    assign ld_wait = ld_valid && ld_super && any_block;

endmodule

// File: rtl/sbuf_dump_ctl.sv
module sbuf_dump_ctl
    import sbuf_pkg::*;
#(
    parameter int DUMP_GAP = 50,
    localparam int GW = $clog2(DUMP_GAP + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic nonempty,
    input  logic head_fault,
    input  logic last_entry,
    input  logic dump_ready,
    output logic running,
    output logic exc_pulse,
    output logic dump_valid,
    output logic dump_pop
);

    dump_state_t   state;
    logic [GW-1:0] gap_cnt;

    assign running    = (state == DS_RUN);
    assign exc_pulse  = running && nonempty && head_fault;
    assign dump_valid = (state == DS_SEND);
    assign dump_pop   = dump_valid && dump_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= DS_RUN;
            gap_cnt <= '0;
        end else begin
            case (state)
                DS_RUN: begin
                    if (exc_pulse) begin
                        state   <= DS_GAP;
                        gap_cnt <= '0;
                    end
                end
                DS_GAP: begin
                    if (gap_cnt == GW'(DUMP_GAP - 1)) state <= DS_SEND;
                    else gap_cnt <= gap_cnt + GW'(1);
                end
                DS_SEND: begin
                    if (dump_ready) begin
                        gap_cnt <= '0;
                        state   <= last_entry ? DS_RUN : DS_GAP;
                    end
                end
                default: state <= DS_RUN;
            endcase
        end
    end

    AST_EXC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        exc_pulse |=> !exc_pulse && !running); // R7
    AST_DUMP_HOLD: assert property (@(posedge clk) disable iff (rst)
        dump_valid && !dump_ready |=> dump_valid); // R8
    AST_GAP_BEFORE_SEND: assert property (@(posedge clk) disable iff (rst)
        $rose(dump_valid) |-> $past(state) == DS_GAP); // R8

endmodule

// File: rtl/sup_store_buffer.sv
module sup_store_buffer
    import sbuf_pkg::*;
#(
    parameter int DEPTH    = 4,
    parameter int DUMP_GAP = 50,
    parameter int BLK_LSB  = 6,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             st_valid,
    input  logic [31:0]      st_addr,
    input  logic [31:0]      st_data,
    input  logic             st_super,
    input  logic             st_fault,
    output logic             st_stall,
    input  logic             ld_valid,
    input  logic [31:0]      ld_addr,
    input  logic             ld_super,
    output logic             ld_hit,
    output logic [31:0]      ld_data,
    output logic             ld_wait,
    output logic             wr_valid,
    output logic [31:0]      wr_addr,
    output logic [31:0]      wr_data,
    input  logic             wr_ready,
    output logic             exc_pulse,
    output logic             busy,
    output logic             dump_valid,
    output logic [31:0]      dump_addr,
    output logic [31:0]      dump_data,
    output logic             dump_super,
    input  logic             dump_ready
);

    sb_entry_t        head_ent;
    sb_entry_t        new_ent;
    logic [PW-1:0]    head_ptr;
    logic [CW-1:0]    count;
    logic [SB_AW-1:0] addr_q [DEPTH];
    logic [SB_DW-1:0] data_q [DEPTH];
    logic             running;
    logic             dump_pop;
    logic             nonempty;
    logic             push;
    logic             pop;

    assign nonempty = (count != '0);
    assign st_stall = (count == CW'(DEPTH)) || !running;
    assign push     = st_valid && !st_stall;

    // The fault result only matters for supervised stores.
    assign new_ent.addr  = st_addr;
    assign new_ent.data  = st_data;
    assign new_ent.sup   = st_super;
    assign new_ent.fault = st_super && st_fault;

    assign wr_valid = running && nonempty && !head_ent.fault;
    assign wr_addr  = head_ent.addr;
    assign wr_data  = head_ent.data;
    assign pop      = (wr_valid && wr_ready) || dump_pop;

    assign busy       = !running;
    assign dump_addr  = head_ent.addr;
    assign dump_data  = head_ent.data;
    assign dump_super = head_ent.sup;

    sbuf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_ent (new_ent),
        .pop      (pop),
        .head_ent (head_ent),
        .head_ptr (head_ptr),
        .count    (count),
        .addr_q   (addr_q),
        .data_q   (data_q)
    );

    sbuf_lookup #(.DEPTH(DEPTH), .BLK_LSB(BLK_LSB)) u_lookup (
        .addr_q   (addr_q),
        .data_q   (data_q),
        .head_ptr (head_ptr),
        .count    (count),
        .ld_valid (ld_valid),
        .ld_addr  (ld_addr),
        .ld_super (ld_super),
        .ld_hit   (ld_hit),
        .ld_data  (ld_data),
        .ld_wait  (ld_wait)
    );

    sbuf_dump_ctl #(.DUMP_GAP(DUMP_GAP)) u_dump (
        .clk        (clk),
        .rst        (rst),
        .nonempty   (nonempty),
        .head_fault (head_ent.fault),
        .last_entry (count == CW'(1)),
        .dump_ready (dump_ready),
        .running    (running),
        .exc_pulse  (exc_pulse),
        .dump_valid (dump_valid),
        .dump_pop   (dump_pop)
    );

    AST_WR_STABLE: assert property (@(posedge clk) disable iff (rst)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R2
    AST_SUP_NO_FWD: assert property (@(posedge clk) disable iff (rst)
        ld_valid && ld_super |-> !ld_hit); // R5
    AST_NO_WR_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !wr_valid); // R9
    AST_DUMP_FIELDS_HELD: assert property (@(posedge clk) disable iff (rst)
        dump_valid && !dump_ready |=> $stable(dump_addr) && $stable(dump_data)); // R8
    AST_DUMP_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        dump_valid |-> busy && st_stall); // R9

endmodule

// File: tb/sim_sup_store_buffer.sv
module sim_sup_store_buffer;

    localparam int GAP = 50;
    localparam int BLK = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic st_valid = 0, st_super = 0, st_fault = 0;
    logic [31:0] st_addr = 0, st_data = 0;
    logic ld_valid = 0, ld_super = 0;
    logic [31:0] ld_addr = 0;
    logic wr_ready = 0, dump_ready = 0;
    logic st_stall, ld_hit, ld_wait, wr_valid, exc_pulse, busy, dump_valid, dump_super;
    logic [31:0] ld_data, wr_addr, wr_data, dump_addr, dump_data;

    int checks = 0;
    int failures = 0;

    // behavioural model state
    logic [31:0] m_addr[$];
    logic [31:0] m_data[$];
    bit          m_sup[$];
    bit          m_flt[$];
    int          m_state = 0;   // 0 run, 1 gap, 2 send
    int          m_gap = 0;

    always #10 clk = ~clk;

    sup_store_buffer #(.DEPTH(4), .DUMP_GAP(GAP), .BLK_LSB(BLK)) u0 (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
        .st_super(st_super), .st_fault(st_fault), .st_stall(st_stall),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_super(ld_super),
        .ld_hit(ld_hit), .ld_data(ld_data), .ld_wait(ld_wait),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .exc_pulse(exc_pulse), .busy(busy),
        .dump_valid(dump_valid), .dump_addr(dump_addr), .dump_data(dump_data),
        .dump_super(dump_super), .dump_ready(dump_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        int  n = m_addr.size();
        bit  e_stall = (n == 4) || (m_state != 0);
        bit  e_wr = (m_state == 0) && n > 0 && !m_flt[0];
        bit  e_exc = (m_state == 0) && n > 0 && m_flt[0];
        bit  e_dv = (m_state == 2);
        bit  hit = 0, blk = 0;
        logic [31:0] fdata = 0;
        for (int i = 0; i < n; i++) begin
            if (m_addr[i] == ld_addr) begin hit = 1; fdata = m_data[i]; end
            if ((m_addr[i] >> BLK) == (ld_addr >> BLK)) blk = 1;
        end
        chk(st_stall == e_stall, "R3/R9", "st_stall", st_stall, e_stall);
        chk(wr_valid == e_wr, "R2/R7", "wr_valid", wr_valid, e_wr);
        if (e_wr) begin
            chk(wr_addr == m_addr[0], "R2", "wr_addr", wr_addr, m_addr[0]);
            chk(wr_data == m_data[0], "R2", "wr_data", wr_data, m_data[0]);
        end
        chk(exc_pulse == e_exc, "R7", "exc_pulse", exc_pulse, e_exc);
        chk(busy == (m_state != 0), "R9", "busy", busy, m_state != 0);
        chk(dump_valid == e_dv, "R8", "dump_valid", dump_valid, e_dv);
        if (e_dv) begin
            chk(dump_addr == m_addr[0], "R8", "dump_addr", dump_addr, m_addr[0]);
            chk(dump_data == m_data[0], "R8", "dump_data", dump_data, m_data[0]);
            chk(dump_super == m_sup[0], "R8", "dump_super", dump_super, m_sup[0]);
        end
        if (ld_valid && ld_super) begin
            chk(ld_hit == 1'b0, "R5", "ld_hit super", ld_hit, 0);
            chk(ld_wait == blk, "R6", "ld_wait", ld_wait, blk);
        end else if (ld_valid) begin
            chk(ld_hit == hit, "R4", "ld_hit", ld_hit, hit);
            if (hit) chk(ld_data == fdata, "R4", "ld_data", ld_data, fdata);
            chk(ld_wait == 1'b0, "R6", "ld_wait plain", ld_wait, 0);
        end
    endtask

    task automatic model_step();
        int n = m_addr.size();
        bit stall = (n == 4) || (m_state != 0);
        bit wr = (m_state == 0) && n > 0 && !m_flt[0];
        bit exc = (m_state == 0) && n > 0 && m_flt[0];
        bit pop = (wr && wr_ready) || (m_state == 2 && dump_ready);
        int nxt = m_state;
        if (m_state == 0 && exc) begin nxt = 1; m_gap = 0; end
        else if (m_state == 1) begin
            if (m_gap == GAP - 1) nxt = 2; else m_gap++;
        end else if (m_state == 2 && dump_ready) begin
            nxt = (n == 1) ? 0 : 1; m_gap = 0;
        end
        if (pop) begin
            void'(m_addr.pop_front()); void'(m_data.pop_front());
            void'(m_sup.pop_front());  void'(m_flt.pop_front());
        end
        if (st_valid && !stall) begin
            m_addr.push_back(st_addr); m_data.push_back(st_data);
            m_sup.push_back(st_super); m_flt.push_back(st_super && st_fault);
        end
        m_state = nxt;
    endtask

    task automatic cyc();
        #1;
        compare();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic put(input logic [31:0] a, input logic [31:0] d, input bit s, input bit f);
        st_valid = 1; st_addr = a; st_data = d; st_super = s; st_fault = f;
        cyc();
        st_valid = 0;
    endtask

    task automatic probe(input logic [31:0] a, input bit s);
        ld_valid = 1; ld_addr = a; ld_super = s;
        cyc();
        ld_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1: reset state
        chk(!st_stall && !wr_valid && !exc_pulse && !busy && !dump_valid && !ld_hit && !ld_wait,
            "R1", "reset outputs", {st_stall, wr_valid, exc_pulse, busy, dump_valid}, 0);
        @(negedge clk);

        // R2/R3/R4: fill while memory stalled, repeated address
        wr_ready = 0;
        put(32'h100, 32'hA1, 0, 0);
        put(32'h104, 32'hA2, 0, 0);
        put(32'h100, 32'hA3, 0, 0);
        put(32'h240, 32'hA4, 1, 0);
        put(32'h300, 32'hDEAD, 0, 0);   // R3: ignored while full
        probe(32'h100, 0);              // R4: youngest -> A3
        probe(32'h108, 0);              // R4: miss
        probe(32'h100, 1);              // R5: no forward; R6 wait
        probe(32'h108, 1);              // R6: same block, wait
        probe(32'h400, 1);              // R6: other block, no wait
        repeat (2) cyc();
        wr_ready = 1;
        repeat (6) cyc();
        probe(32'h100, 1);              // R6: drained -> no wait

        // R10: plain store with fault flag retires normally
        put(32'h500, 32'hB0, 0, 1);
        repeat (3) cyc();

        // R7/R8/R9: faulting supervised store at head
        wr_ready = 0;
        put(32'h600, 32'hC0, 1, 1);
        put(32'h604, 32'hC1, 0, 0);
        put(32'h700, 32'hC2, 1, 0);
        dump_ready = 0;
        put(32'h800, 32'hEE, 0, 0);     // R9: ignored during dump
        for (int k = 0; k < 4 * (GAP + 6); k++) begin
            dump_ready = (k % 3) == 2;
            if (k == 20) probe(32'h604, 0); else cyc();
        end
        dump_ready = 0;
        wr_ready = 1;
        repeat (3) cyc();

        // random phase
        for (int k = 0; k < 3000; k++) begin
            st_valid = $urandom_range(0, 1);
            st_addr  = ($urandom_range(0, 3) << BLK) | ($urandom_range(0, 1) << 2);
            st_data  = $urandom;
            st_super = $urandom_range(0, 1);
            st_fault = ($urandom_range(0, 15) == 0);
            ld_valid = $urandom_range(0, 1);
            ld_addr  = ($urandom_range(0, 3) << BLK) | ($urandom_range(0, 1) << 2);
            ld_super = $urandom_range(0, 1);
            wr_ready = $urandom_range(0, 3) != 0;
            dump_ready = $urandom_range(0, 1);
            cyc();
        end
        st_valid = 0; ld_valid = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule